// File: doc/BRIEF.md
# Byte/Word Arithmetic Unit with Status Flags

This block is the arithmetic stage of a small 16-bit accumulator-style processor. Each cycle it takes a destination operand, a source operand, a two-bit operation code and a size select. It then forms the sum, the difference or a plain pass-through of the source. The result and its destination write-enable are combinational. A comparison does the same subtraction as a subtract, but it holds the write-enable low, so only the status flags see its outcome.

The status word is a registered 16-bit value. It holds a carry/borrow bit, a zero bit, a sign bit, an overflow bit and an interrupt-enable bit. The flags change on a clock edge, and only when the update strobe is high and the operation is arithmetic. A per-flag write mask limits which of the four arithmetic flags take the new values. A move never disturbs the flags. The interrupt-enable bit changes only through its own write port. Every result and flag follows the operand width selected for that operation.

Top module: `byteWordAlu`

## Requirements
- R1: Operation code 2'b01 (add) drives `result` with dstVal + srcVal, modulo the active width, and raises `destWrite`.
- R2: Code 2'b10 (subtract) drives dstVal − srcVal with `destWrite` high. Code 2'b11 (compare) drives the same difference with `destWrite` low. Code 2'b00 (move) drives srcVal at the active width with `destWrite` high.
- R3: After an update, the zero flag (flags bit 1) is 1 exactly when the result at the active width is all zeros.
- R4: After an update, the sign flag (flags bit 2) equals the top bit of the result at the active width: bit 7 in byte mode, bit 15 in word mode.
- R5: After an update, the carry flag (flags bit 0) holds the carry out of the top bit for add. For subtract and compare it holds the borrow, which is 1 when dst is unsigned-less than src.
- R6: After an update, the overflow flag (flags bit 3) is 1 exactly when the signed result is not representable at the active width.
- R7: With `wordMode` = 0 (byte), `result[15:8]` is zero and the upper operand bytes have no effect on the result or the flags. With `wordMode` = 1 the operation spans all 16 bits.
- R8: The arithmetic flags change only on a rising clock edge where `flagStrobe` is 1 and the code is add, subtract or compare. A move leaves them unchanged even with the strobe high.
- R9: `flagMask` bit i (same positions as flags bits 3:0) enables the write of flags bit i. Unmasked flags keep their value.
- R10: The interrupt-enable flag (flags bit 4) takes `ieData` on an edge with `ieWrite` = 1. No arithmetic operation changes it.
- R11: Synchronous reset `rst` clears the whole flags register. Flags bits 15:5 always read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opCode | input | 2 | 00 move, 01 add, 10 subtract, 11 compare |
| wordMode | input | 1 | 0 = 8-bit operands, 1 = 16-bit operands |
| dstVal | input | 16 | Destination operand (left-hand side) |
| srcVal | input | 16 | Source operand (right-hand side) |
| flagStrobe | input | 1 | Allows the flags to update on this edge |
| flagMask | input | 4 | Per-flag write enables for flags bits 3:0 |
| ieWrite | input | 1 | Write strobe for the interrupt-enable flag |
| ieData | input | 1 | Value for the interrupt-enable flag |
| result | output | 16 | Operation result, zero-extended in byte mode |
| destWrite | output | 1 | Destination write-enable |
| flags | output | 16 | Status register |

## Verification
The bench targets byte operations whose upper operand bytes are non-zero and whose low byte wraps. A design that used the full 16-bit sum would report a non-zero result with no carry and leak upper bits into the result. Signed boundaries come next: 7FFFh+1, 8000h−1 and 7FFFh compared with 8000h. A design that took the overflow sign test from the un-inverted source, or reported the raw carry instead of the borrow on subtract, gets the overflow and carry bits backwards there. Further cases are a move or unstrobed add after known flags, a partial mask and a set interrupt-enable bit. They catch a design that updates flags on every operation, ignores the mask, or lets arithmetic clear the interrupt-enable bit.

// File: rtl/byteWordAluPkg.sv
`timescale 1ns/1ps
package byteWordAluPkg;
  localparam int DATA_W = 16;
  localparam int BYTE_W = 8;
  localparam int ARITH_FLAGS = 4;

  // Flag bit positions inside the status word
  localparam int FLG_CARRY = 0;
  localparam int FLG_ZERO  = 1;
  localparam int FLG_SIGN  = 2;
  localparam int FLG_OVF   = 3;
  localparam int FLG_IEN   = 4;
  localparam int FLG_USED  = 5;

  typedef enum logic [1:0] {
    OP_MOVE = 2'b00,
    OP_ADD  = 2'b01,
    OP_SUB  = 2'b10,
    OP_CMP  = 2'b11
  } aluOp_t;

  typedef struct packed {
    logic subtract;   // invert source, carry-in of one
    logic passSrc;    // move: forward the source
    logic writeDest;  // destination write-enable
    logic arith;      // operation may touch arithmetic flags
  } aluCtrl_t;
endpackage

// File: rtl/byteWordAluControl.sv
`timescale 1ns/1ps
module byteWordAluControl
  import byteWordAluPkg::*;
(
  input  logic [1:0] opCode,
  output aluCtrl_t   ctrl
);
  aluOp_t op;
  assign op = aluOp_t'(opCode);

  always_comb begin
    ctrl = '0;
    unique case (op)
      OP_MOVE: begin
        ctrl.passSrc   = 1'b1;
        ctrl.writeDest = 1'b1;
      end
      OP_ADD: begin
        ctrl.writeDest = 1'b1;
        ctrl.arith     = 1'b1;
      end
      OP_SUB: begin
        ctrl.subtract  = 1'b1;
        ctrl.writeDest = 1'b1;
        ctrl.arith     = 1'b1;
      end
      OP_CMP: begin
        ctrl.subtract  = 1'b1;
        ctrl.arith     = 1'b1;
      end
      default: ctrl = '0;
    endcase
  end
endmodule

// File: rtl/byteWordAluDatapath.sv
`timescale 1ns/1ps
module byteWordAluDatapath
  import byteWordAluPkg::*;
#(
  parameter int W  = DATA_W,
  parameter int BW = BYTE_W
) (
  input  aluCtrl_t               ctrl,
  input  logic                   wordMode,
  input  logic [W-1:0]           dstVal,
  input  logic [W-1:0]           srcVal,
  output logic [W-1:0]           result,
  output logic [ARITH_FLAGS-1:0] newFlags
);
  localparam int UPPER_W = W - BW;

  logic [W-1:0]  opB;
  logic [W:0]    wordSum;
  logic [BW:0]   byteSum;
  logic [W-1:0]  arithRes;
  logic          carryOut;
  logic          dstSign;
  logic          opBSign;
  logic          resSign;

  // Source inverted for subtract; two's complement completed by carry-in
  assign opB = ctrl.subtract ? ~srcVal : srcVal;

  assign wordSum = {1'b0, dstVal} + {1'b0, opB} + {{W{1'b0}}, ctrl.subtract};
  assign byteSum = {1'b0, dstVal[BW-1:0]} + {1'b0, opB[BW-1:0]}
                 + {{BW{1'b0}}, ctrl.subtract};

  always_comb begin
    if (wordMode) begin
      arithRes = wordSum[W-1:0];
      carryOut = wordSum[W];
      dstSign  = dstVal[W-1];
      opBSign  = opB[W-1];
    end else begin
      arithRes = {{UPPER_W{1'b0}}, byteSum[BW-1:0]};
      carryOut = byteSum[BW];
      dstSign  = dstVal[BW-1];
      opBSign  = opB[BW-1];
    end
  end

  assign resSign = wordMode ? arithRes[W-1] : arithRes[BW-1];

  always_comb begin
    if (ctrl.passSrc)
      result = wordMode ? srcVal : {{UPPER_W{1'b0}}, srcVal[BW-1:0]};
    else
      result = arithRes;
  end

  always_comb begin
    newFlags = '0;
    // borrow is the complement of the adder carry when subtracting
    newFlags[FLG_CARRY] = ctrl.subtract ? ~carryOut : carryOut;
    newFlags[FLG_ZERO]  = (arithRes == '0);
    newFlags[FLG_SIGN]  = resSign;
    newFlags[FLG_OVF]   = (dstSign == opBSign) && (resSign != dstSign);
  end
endmodule

// File: rtl/byteWordAluFlagReg.sv
`timescale 1ns/1ps
module byteWordAluFlagReg
  import byteWordAluPkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   updateEn,
  input  logic [ARITH_FLAGS-1:0] writeMask,
  input  logic [ARITH_FLAGS-1:0] newFlags,
  input  logic                   ieWrite,
  input  logic                   ieData,
  output logic [W-1:0]           flagsOut
);
  logic [ARITH_FLAGS-1:0] arithQ;
  logic                   ienQ;

  for (genvar i = 0; i < ARITH_FLAGS; i++) begin : g_flagBit
    always_ff @(posedge clk) begin
      if (rst)
        arithQ[i] <= 1'b0;
      else if (updateEn && writeMask[i])
        arithQ[i] <= newFlags[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      ienQ <= 1'b0;
    else if (ieWrite)
      ienQ <= ieData;
  end

  always_comb begin
    flagsOut = '0;
    flagsOut[ARITH_FLAGS-1:0] = arithQ;
    flagsOut[FLG_IEN] = ienQ;
  end
endmodule

// File: rtl/byteWordAlu.sv
`timescale 1ns/1ps
module byteWordAlu
  import byteWordAluPkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [1:0]  opCode,
  input  logic        wordMode,
  input  logic [15:0] dstVal,
  input  logic [15:0] srcVal,
  input  logic        flagStrobe,
  input  logic [3:0]  flagMask,
  input  logic        ieWrite,
  input  logic        ieData,
  output logic [15:0] result,
  output logic        destWrite,
  output logic [15:0] flags
);
  aluCtrl_t               ctrl;
  logic [ARITH_FLAGS-1:0] newFlags;

  byteWordAluControl u_ctrl (
    .opCode (opCode),
    .ctrl   (ctrl)
  );

  byteWordAluDatapath #(.W(DATA_W), .BW(BYTE_W)) u_dp (
    .ctrl     (ctrl),
    .wordMode (wordMode),
    .dstVal   (dstVal),
    .srcVal   (srcVal),
    .result   (result),
    .newFlags (newFlags)
  );

  byteWordAluFlagReg #(.W(DATA_W)) u_flags (
    .clk       (clk),
    .rst       (rst),
    .updateEn  (flagStrobe && ctrl.arith),
    .writeMask (flagMask),
    .newFlags  (newFlags),
    .ieWrite   (ieWrite),
    .ieData    (ieData),
    .flagsOut  (flags)
  );

  assign destWrite = ctrl.writeDest;
endmodule

// File: rtl/byteWordAluChecker.sv
`timescale 1ns/1ps
module byteWordAluChecker (
  input logic        clk,
  input logic        rst,
  input logic [1:0]  opCode,
  input logic        wordMode,
  input logic [15:0] dstVal,
  input logic [15:0] srcVal,
  input logic        flagStrobe,
  input logic [3:0]  flagMask,
  input logic        ieWrite,
  input logic        ieData,
  input logic [15:0] result,
  input logic        destWrite,
  input logic [15:0] flags
);
  logic arithUpd;
  assign arithUpd = flagStrobe && (opCode != 2'b00);

  AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (opCode == 2'b11) |-> !destWrite); // R2

  AST_ADD_SUM: assert property (@(posedge clk) disable iff (rst)
    (opCode == 2'b01 && wordMode) |-> (result == dstVal + srcVal)); // R1

  AST_ZERO_TRACK: assert property (@(posedge clk) disable iff (rst)
    (arithUpd && flagMask[1]) |=> (flags[1] == ($past(result) == 16'h0000))); // R3

  AST_SIGN_TRACK: assert property (@(posedge clk) disable iff (rst)
    (arithUpd && flagMask[2])
      |=> (flags[2] == $past(wordMode ? result[15] : result[7]))); // R4

  AST_BYTE_UPPER: assert property (@(posedge clk) disable iff (rst)
    !wordMode |-> (result[15:8] == 8'h00)); // R7

  AST_NO_UPDATE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !arithUpd |=> $stable(flags[3:0])); // R8

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (arithUpd && !flagMask[0]) |=> $stable(flags[0])); // R9

  AST_IE_KEPT: assert property (@(posedge clk) disable iff (rst)
    !ieWrite |=> $stable(flags[4])); // R10

  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (rst)
    flags[15:5] == 11'h000); // R11

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (flags == 16'h0000)); // R11

  logic unusedIn;
  assign unusedIn = ieData;
endmodule

bind byteWordAlu byteWordAluChecker u_chk (.*);

// File: tb/byteWordAlu_test.sv
`timescale 1ns/1ps
module byteWordAlu_test;
  logic        clk = 1'b0;
  logic        rst;
  logic [1:0]  opCode;
  logic        wordMode;
  logic [15:0] dstVal;
  logic [15:0] srcVal;
  logic        flagStrobe;
  logic [3:0]  flagMask;
  logic        ieWrite;
  logic        ieData;
  logic [15:0] result;
  logic        destWrite;
  logic [15:0] flags;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  byteWordAlu uut (
    .clk(clk), .rst(rst), .opCode(opCode), .wordMode(wordMode),
    .dstVal(dstVal), .srcVal(srcVal), .flagStrobe(flagStrobe),
    .flagMask(flagMask), .ieWrite(ieWrite), .ieData(ieData),
    .result(result), .destWrite(destWrite), .flags(flags)
  );

  // {op, wordMode, dst, src, expResult, expDestWrite, expFlags[3:0]}
  // flag nibble: bit3 overflow, bit2 sign, bit1 zero, bit0 carry
  localparam int NVEC = 11;
  localparam logic [55:0] VEC [NVEC] = '{
    {2'b01, 1'b0, 16'h0073, 16'h0040, 16'h00B3, 1'b1, 4'hC}, // R1 R4 R6 byte add
    {2'b01, 1'b1, 16'h7FFF, 16'h0001, 16'h8000, 1'b1, 4'hC}, // R6 word overflow
    {2'b01, 1'b1, 16'hFFFF, 16'h0001, 16'h0000, 1'b1, 4'h3}, // R3 R5 carry, zero
    {2'b01, 1'b0, 16'h12FF, 16'h3401, 16'h0000, 1'b1, 4'h3}, // R7 upper ignored
    {2'b10, 1'b1, 16'h0005, 16'h0007, 16'hFFFE, 1'b1, 4'h5}, // R2 R5 borrow
    {2'b10, 1'b0, 16'hAB80, 16'hCD01, 16'h007F, 1'b1, 4'h8}, // R6 R7 byte sub ovf
    {2'b11, 1'b1, 16'h7FFF, 16'h8000, 16'hFFFF, 1'b0, 4'hD}, // R2 R5 R6 compare
    {2'b11, 1'b1, 16'h1234, 16'h1234, 16'h0000, 1'b0, 4'h2}, // R2 R3 equal
    {2'b10, 1'b1, 16'h8000, 16'h0001, 16'h7FFF, 1'b1, 4'h8}, // R6 neg minus pos
    {2'b00, 1'b1, 16'h0000, 16'hBEEF, 16'hBEEF, 1'b1, 4'h8}, // R2 R8 move keeps flags
    {2'b00, 1'b0, 16'h1111, 16'hBEEF, 16'h00EF, 1'b1, 4'h8}  // R7 R8 byte move
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] op, input logic w, input logic [15:0] d,
                       input logic [15:0] s, input logic stb, input logic [3:0] msk,
                       input logic iw, input logic id);
    @(negedge clk);
    opCode = op; wordMode = w; dstVal = d; srcVal = s;
    flagStrobe = stb; flagMask = msk; ieWrite = iw; ieData = id;
  endtask

  task automatic afterEdge();
    @(posedge clk);
    #3;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    opCode = 2'b00; wordMode = 1'b1; dstVal = '0; srcVal = '0;
    flagStrobe = 1'b0; flagMask = 4'h0; ieWrite = 1'b0; ieData = 1'b0;
    repeat (3) @(posedge clk);
    #3;
    check("R11 reset flags", flags, 16'h0000);
    @(negedge clk);
    rst = 1'b0;

    // table walk, full mask and strobe on every vector
    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i][55:54], VEC[i][53], VEC[i][52:37], VEC[i][36:21],
            1'b1, 4'hF, 1'b0, 1'b0);
      #3;
      check("R1 R2 R7 result", result, VEC[i][20:5]);
      check("R2 destWrite", {15'h0, destWrite}, {15'h0, VEC[i][4]});
      afterEdge();
      check("R3 R4 R5 R6 R8 flags", flags, {12'h000, VEC[i][3:0]});
    end

    // R8: strobe low, add that would give 3 leaves flags at B
    drive(2'b01, 1'b1, 16'h8000, 16'h8000, 1'b1, 4'hF, 1'b0, 1'b0);
    afterEdge();
    check("R6 R5 word add both negative", flags, 16'h000B);
    drive(2'b01, 1'b1, 16'hFFFF, 16'h0001, 1'b0, 4'hF, 1'b0, 1'b0);
    afterEdge();
    check("R8 no strobe holds flags", flags, 16'h000B);

    // R9: set flags to 3, then sign-only mask on an add that yields C
    drive(2'b01, 1'b1, 16'hFFFF, 16'h0001, 1'b1, 4'hF, 1'b0, 1'b0);
    afterEdge();
    check("R9 setup", flags, 16'h0003);
    drive(2'b01, 1'b1, 16'h7FFF, 16'h0001, 1'b1, 4'b0100, 1'b0, 1'b0);
    afterEdge();
    check("R9 sign only written", flags, 16'h0007);
    drive(2'b11, 1'b1, 16'h0001, 16'h0002, 1'b1, 4'h0, 1'b0, 1'b0);
    afterEdge();
    check("R9 empty mask", flags, 16'h0007);

    // R10: interrupt-enable set, then arithmetic must keep it
    drive(2'b00, 1'b1, 16'h0000, 16'h0000, 1'b0, 4'h0, 1'b1, 1'b1);
    afterEdge();
    check("R10 ie set", flags, 16'h0017);
    drive(2'b10, 1'b1, 16'h1234, 16'h1234, 1'b1, 4'hF, 1'b0, 1'b0);
    afterEdge();
    check("R10 arithmetic keeps ie", flags, 16'h0012);
    drive(2'b00, 1'b1, 16'hFFFF, 16'hFFFF, 1'b1, 4'hF, 1'b0, 1'b0);
    afterEdge();
    check("R8 move with strobe", flags, 16'h0012);
    check("R11 unused bits", {5'h0, flags[15:5]}, 16'h0000);
    drive(2'b00, 1'b1, 16'h0000, 16'h0000, 1'b0, 4'h0, 1'b1, 1'b0);
    afterEdge();
    check("R10 ie clear", flags, 16'h0002);

    // R11: reset with flags and ie set clears everything
    drive(2'b00, 1'b1, 16'h0000, 16'h0000, 1'b0, 4'h0, 1'b1, 1'b1);
    afterEdge();
    @(negedge clk);
    rst = 1'b1;
    ieWrite = 1'b0;
    afterEdge();
    check("R11 reset clears", flags, 16'h0000);
    rst = 1'b0;

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule